// File: doc/BRIEF.md
# Tunable Phase and Amplitude Word Generator

This block is the numeric front end of a direct digital synthesizer. On every system clock it advances a 32-bit phase accumulator by a tuning word and delivers a 16-bit phase word and a 14-bit amplitude word to a downstream phase-to-amplitude converter. The output frequency is the tuning word divided by 2^32, times the clock rate. For example, a tuning word of 0x1FFFFFC0 at a 1 GHz clock gives roughly 124.99999 MHz. A 16-bit phase offset is added after the accumulator, and its full scale spans one turn, so 0xFFFF is about 359.995 degrees.

A separate ramp generator supplies a 32-bit unsigned modulation bus. A 2-bit target selector steers that bus onto one of three parameters: the tuning word, the phase offset or the amplitude scale. The bus is aligned at its most significant bit with the chosen parameter. When the target is phase or amplitude, the bits below the parameter's width are discarded. Phase modulation acts only on the offset that is added after the accumulator and never disturbs the accumulator's own state. The tuning word, offset, scale and target selector are captured together on a load strobe. The modulation bus is registered on every clock.

Top module: `dds_mod_core`

## Requirements
- R1: Each clock, the accumulator adds the effective tuning word modulo 2^32. Tuning word, offset, scale and target are loaded at edge E1. After the k-th edge that follows E1 (k >= 1), `phase_word` equals bits 31:16 of ((k-1) x tuning word) plus the effective offset, modulo 2^16.
- R2: The tuning word, offset, scale and target inputs are captured only on a clock edge where `cfg_load` is high. At any other edge they are ignored.
- R3: With `mod_sel` = 2'b00, the registered modulation bus replaces the tuning word in the accumulation.
- R4: With `mod_sel` = 2'b01, bits 31:16 of the registered modulation bus replace the phase offset. Bits 15:0 are ignored, and the accumulator still advances by the loaded tuning word.
- R5: With `mod_sel` = 2'b10 or 2'b11, bits 31:18 of the registered modulation bus replace the amplitude scale and bits 17:0 are ignored. With 2'b00 or 2'b01, `amp_word` shows the loaded scale.
- R6: `mod_bus` is sampled on every clock without a strobe. A change on it reaches `amp_word` at the second clock edge after it is applied.
- R7: A synchronous active-high `rst` clears the accumulator, the loaded parameters, the modulation register and both outputs to zero at the next edge. They stay zero while `rst` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for tuning word, offset, scale and target |
| tune_word | input | 32 | Frequency tuning word |
| phase_ofs | input | 16 | Phase offset, full scale = 360 degrees |
| amp_scale | input | 14 | Amplitude scale |
| mod_sel | input | 2 | Modulation target: 00 frequency, 01 phase, 10/11 amplitude |
| mod_bus | input | 32 | Unsigned modulation value from the ramp generator |
| phase_word | output | 16 | Registered phase word to the converter |
| amp_word | output | 14 | Registered amplitude word to the converter |

## Verification
On every cycle, the assertions check the routing for each target. They confirm that the phase word follows the accumulator top bits plus the right offset source, that the amplitude word follows either the scale or the upper bus bits, and that frequency targeting steps the accumulator by the bus value. They also check that loaded parameters hold between strobes and that reset zeroes everything. Only the bench scenarios show the absolute arithmetic. These cover the exact phase after a known number of cycles, wrap-around of both the accumulator and the offset sum, the discarding of low bus bits under concrete values, and the two-cycle latency from the bus to the amplitude output.

// File: rtl/dds_pkg.sv
package dds_pkg;
  // modulation target selector
  typedef enum logic [1:0] {
    MOD_TO_FREQ    = 2'b00,
    MOD_TO_PHASE   = 2'b01,
    MOD_TO_AMP     = 2'b10,
    MOD_TO_AMP_ALT = 2'b11
  } mod_dest_e;
endpackage

// File: rtl/dds_cfg_regs.sv
module dds_cfg_regs
  import dds_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [ACC_W-1:0]   tune_d,
  input  logic [PHASE_W-1:0] ofs_d,
  input  logic [AMP_W-1:0]   scale_d,
  input  mod_dest_e          dest_d,
  output logic [ACC_W-1:0]   tune_q,
  output logic [PHASE_W-1:0] ofs_q,
  output logic [AMP_W-1:0]   scale_q,
  output mod_dest_e          dest_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tune_q  <= '0;
      ofs_q   <= '0;
      scale_q <= '0;
      dest_q  <= MOD_TO_FREQ;
    end else if (load) begin
      tune_q  <= tune_d;
      ofs_q   <= ofs_d;
      scale_q <= scale_d;
      dest_q  <= dest_d;
    end
  end

  // R2: parameters only move on a strobe
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(tune_q) && $stable(ofs_q) && $stable(scale_q) && $stable(dest_q)));

  a_r2_cfg_take: assert property (@(posedge clk) disable iff (rst)
    load |=> (tune_q == $past(tune_d) && scale_q == $past(scale_d)));

endmodule

// File: rtl/dds_mod_router.sv
module dds_mod_router
  import dds_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 14,
  parameter int MOD_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MOD_W-1:0]   mod_bus,
  input  logic [ACC_W-1:0]   tune_q,
  input  logic [PHASE_W-1:0] ofs_q,
  input  logic [AMP_W-1:0]   scale_q,
  input  mod_dest_e          dest_q,
  output logic [MOD_W-1:0]   mod_q,
  output logic [ACC_W-1:0]   step_eff,
  output logic [PHASE_W-1:0] ofs_eff,
  output logic [AMP_W-1:0]   scale_eff
);

  localparam int PH_LSB  = MOD_W - PHASE_W;
  localparam int AMP_LSB = MOD_W - AMP_W;

  logic [ACC_W-1:0]   mod_freq;
  logic [PHASE_W-1:0] mod_phase;
  logic [AMP_W-1:0]   mod_amp;

  always_ff @(posedge clk) begin
    if (rst) mod_q <= '0;
    else     mod_q <= mod_bus;
  end

  // MSB alignment of the bus onto the frequency parameter
  generate
    if (MOD_W >= ACC_W) begin : g_freq_trunc
      assign mod_freq = mod_q[MOD_W-1 -: ACC_W];
    end else begin : g_freq_pad
      assign mod_freq = {mod_q, {(ACC_W-MOD_W){1'b0}}};
    end
  endgenerate

  assign mod_phase = mod_q[MOD_W-1:PH_LSB];
  assign mod_amp   = mod_q[MOD_W-1:AMP_LSB];

  always_comb begin
    step_eff  = tune_q;
    ofs_eff   = ofs_q;
    scale_eff = scale_q;
    unique case (dest_q)
      MOD_TO_FREQ:                step_eff  = mod_freq;
      MOD_TO_PHASE:               ofs_eff   = mod_phase;
      MOD_TO_AMP, MOD_TO_AMP_ALT: scale_eff = mod_amp;
      default: ;
    endcase
  end

endmodule

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc
);

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + step;
  end

endmodule

// File: rtl/dds_mod_core.sv
module dds_mod_core
  import dds_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 14,
  parameter int MOD_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_load,
  input  logic [ACC_W-1:0]   tune_word,
  input  logic [PHASE_W-1:0] phase_ofs,
  input  logic [AMP_W-1:0]   amp_scale,
  input  logic [1:0]         mod_sel,
  input  logic [MOD_W-1:0]   mod_bus,
  output logic [PHASE_W-1:0] phase_word,
  output logic [AMP_W-1:0]   amp_word
);

  localparam int ACC_TOP = ACC_W - PHASE_W;

  logic [ACC_W-1:0]   tune_q, step_eff, acc;
  logic [PHASE_W-1:0] ofs_q, ofs_eff;
  logic [AMP_W-1:0]   scale_q, scale_eff;
  logic [MOD_W-1:0]   mod_q;
  mod_dest_e          dest_q;

  dds_cfg_regs #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .tune_d(tune_word), .ofs_d(phase_ofs), .scale_d(amp_scale),
    .dest_d(mod_dest_e'(mod_sel)),
    .tune_q(tune_q), .ofs_q(ofs_q), .scale_q(scale_q), .dest_q(dest_q)
  );

  dds_mod_router #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .AMP_W(AMP_W), .MOD_W(MOD_W)) u_route (
    .clk(clk), .rst(rst), .mod_bus(mod_bus),
    .tune_q(tune_q), .ofs_q(ofs_q), .scale_q(scale_q), .dest_q(dest_q),
    .mod_q(mod_q), .step_eff(step_eff), .ofs_eff(ofs_eff), .scale_eff(scale_eff)
  );

  dds_phase_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .step(step_eff), .acc(acc)
  );

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_word <= '0;
      amp_word   <= '0;
    end else begin
      phase_word <= acc[ACC_W-1:ACC_TOP] + ofs_eff;
      amp_word   <= scale_eff;
    end
  end

  // R7: reset zeroes state and outputs
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (acc == '0 && phase_word == '0 && amp_word == '0 && mod_q == '0));

  // R4: phase target replaces the offset with the upper bus bits
  a_r4_phase_route: assert property (@(posedge clk) disable iff (rst)
    (dest_q == MOD_TO_PHASE) |=>
      phase_word == $past(acc[ACC_W-1:ACC_TOP] + mod_q[MOD_W-1 -: PHASE_W]));

  // R1: other targets add the loaded offset to the accumulator top bits
  a_r1_phase_sum: assert property (@(posedge clk) disable iff (rst)
    (dest_q != MOD_TO_PHASE) |=> phase_word == $past(acc[ACC_W-1:ACC_TOP] + ofs_q));

  // R5: amplitude source follows the target
  a_r5_amp_mod: assert property (@(posedge clk) disable iff (rst)
    dest_q[1] |=> amp_word == $past(mod_q[MOD_W-1 -: AMP_W]));

  a_r5_amp_reg: assert property (@(posedge clk) disable iff (rst)
    !dest_q[1] |=> amp_word == $past(scale_q));

  // R3: frequency target steps the accumulator by the bus value
  generate
    if (MOD_W == ACC_W) begin : g_freq_chk
      a_r3_freq_route: assert property (@(posedge clk) disable iff (rst)
        (dest_q == MOD_TO_FREQ) |=> acc == $past(acc) + $past(mod_q));
    end
  endgenerate

endmodule

// File: tb/test_dds_mod_core.sv
`timescale 1ns/1ps
module test_dds_mod_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [31:0] tune_word = '0;
  logic [15:0] phase_ofs = '0;
  logic [13:0] amp_scale = '0;
  logic [1:0]  mod_sel = '0;
  logic [31:0] mod_bus = '0;
  logic [15:0] phase_word;
  logic [13:0] amp_word;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dds_mod_core i_dds_mod_core (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .tune_word(tune_word), .phase_ofs(phase_ofs), .amp_scale(amp_scale),
    .mod_sel(mod_sel), .mod_bus(mod_bus),
    .phase_word(phase_word), .amp_word(amp_word)
  );

  typedef struct packed {
    logic [31:0] ftw;
    logic [15:0] pow;
    logic [13:0] asf;
    logic [1:0]  sel;
    logic [31:0] ramp;
    logic [7:0]  n;
    logic [15:0] exp_ph;
    logic [13:0] exp_amp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    // R5: amplitude from bus top bits, phase steps by tuning word
    '{32'h0001_0000, 16'h0000, 14'h1234, 2'b10, 32'hFFFC_0000, 8'd5, 16'h0004, 14'h3FFF, 8'd5},
    // R4: bus top half replaces offset, accumulator still advances
    '{32'h0001_0000, 16'h0100, 14'h1234, 2'b01, 32'h8000_0000, 8'd3, 16'h8002, 14'h1234, 8'd4},
    // R3: bus replaces the tuning word
    '{32'h0001_0000, 16'h0010, 14'h0ABC, 2'b00, 32'h0003_0000, 8'd4, 16'h0019, 14'h0ABC, 8'd3},
    // R1: ~125 MHz word; bus low bits dropped for amplitude
    '{32'h1FFF_FFC0, 16'h0000, 14'h3FFF, 2'b10, 32'h0003_FFFF, 8'd9, 16'hFFFF, 14'h0000, 8'd1},
    // R1: accumulator wrap and offset sum wrap
    '{32'h8000_0000, 16'hFFFF, 14'h0000, 2'b10, 32'h0004_0000, 8'd4, 16'h7FFF, 14'h0001, 8'd1},
    // R5: selector 11 also targets amplitude
    '{32'h0000_0000, 16'h4000, 14'h0000, 2'b11, 32'h1234_5678, 8'd2, 16'h4000, 14'h048D, 8'd5},
    // R4: low 16 bus bits ignored for phase target
    '{32'h0000_0000, 16'h1111, 14'h2222, 2'b01, 32'h0000_FFFF, 8'd2, 16'h0000, 14'h2222, 8'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_cfg(input logic [31:0] f, input logic [15:0] p,
                          input logic [13:0] a, input logic [1:0] s);
    tune_word = f; phase_ofs = p; amp_scale = a; mod_sel = s;
    cfg_load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_load = 1'b0;
    // R2: junk on the parameter inputs without a strobe must be ignored
    tune_word = 32'hFFFF_FFFF; phase_ofs = 16'hAAAA; amp_scale = 14'h1555; mod_sel = ~s;
  endtask

  task automatic run_vector(input vec_t v, input int idx);
    do_reset(2);
    mod_bus = v.ramp;
    load_cfg(v.ftw, v.pow, v.asf, v.sel);
    repeat (int'(v.n)) @(posedge clk);
    @(negedge clk);
    chk($sformatf("R%0d/R2 vec%0d phase", v.req, idx), 32'(phase_word), 32'(v.exp_ph));
    chk($sformatf("R%0d/R2 vec%0d amp", v.req, idx), 32'(amp_word), 32'(v.exp_amp));
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R7: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset phase/amp", {phase_word, 2'b00, amp_word}, 32'h0);

    for (int i = 0; i < NVEC; i++) run_vector(VECS[i], i);

    // R6: bus change reaches amplitude on the second edge
    do_reset(2);
    mod_bus = 32'h0;
    load_cfg(32'h0, 16'h0, 14'h0155, 2'b10);
    mod_bus = 32'h0008_0000;
    @(posedge clk);
    @(negedge clk);
    chk("R6 amp before second edge", 32'(amp_word), 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 amp after second edge", 32'(amp_word), 32'h2);

    // R7: reset in the middle of a run clears and holds
    do_reset(2);
    mod_bus = 32'h0004_0000;
    load_cfg(32'h0100_0000, 16'h0123, 14'h0AAA, 2'b10);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R7 running phase nonzero", 32'(phase_word), 32'h0523);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R7 mid-run reset", {phase_word, 2'b00, amp_word}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 reset held", {phase_word, 2'b00, amp_word}, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    finish_run();
  end

endmodule